// File: doc/BRIEF.md
# Signal Instruction Control Sequencer

This block is the control core of a signal-access engine. It runs one instruction at a time over a fixed span of twelve clock cycles. The instruction is fetched from an instruction memory and split into an operation code, a signal identifier and a signal value. The block then forms addresses into a property ROM that holds eight words for each signal, and it steers an address multiplexer across five address registers. It reads an 8-byte PDU window, and in cycle 10 it writes the result to an output buffer and, for send operations, back into the PDU memory.

The arithmetic that places and extracts a signal is outside this block. It is stood in for by a registered pass-through. A send replaces the low value-width bits of the window with the signal value. A receive returns those low bits, zero-extended. The long variants fit three extra ROM reads into the same twelve cycles and deliver the words they read as the real PDU id, the start position and the length.

Cycle numbers below count from 0, the fetch cycle. A register "holds a value from cycle N" when its load strobe is high in cycle N-1.

Top module: `sig_seq_ctrl`

## Requirements
- R1: While idle, a start sampled high makes the next cycle the fetch cycle (cycle 0). In that cycle `imem_rd` is high and `imem_addr` equals an instruction counter that is 0 after reset and goes up by one for each instruction. `done` is a one-cycle pulse in cycle 11. The block is idle in the cycle that follows.
- R2: A start that arrives during cycles 0 to 11 is ignored. The running instruction keeps its timing, and no second fetch begins.
- R3: The instruction word is 15 bits wide. Bits [14:12] hold the operation code: 0 send, 1 receive, 2 long send, 3 long receive, and 4 to 7 undefined. Bits [11:8] hold the signal id and bits [7:0] hold the value.
- R4: `addr_ld` bit 0 is high in cycle 1 and bit 1 in cycle 2. For long operations only, bits 2, 3 and 4 are high in cycles 3, 4 and 5. No other bits are set.
- R5: `rom_rd` is high in cycle 4, with address id*8+2 and select 0, and in cycle 5, with address id*8+3 and select 1. For long operations it is also high in cycles 6, 7 and 8, with addresses id*8+5, +6 and +7 and selects 2, 3 and 4. There is no other ROM read.
- R6: `pdu_rd` is high in cycle 6 only. `pdu_addr` then equals the low 8 bits of the ROM word read in cycle 4. `place_props` equals the ROM word read in cycle 5.
- R7: Send operations (codes 0 and 2) raise `pdu_wr` in cycle 10 at the same address. The write data is the window read in cycle 6 with bits [7:0] replaced by the value. Other codes never write.
- R8: For codes 0 to 3, `obuf_wr` is high in cycle 10. `obuf_data` is the merged window for sends and the zero-extended window bits [7:0] for receives.
- R9: For long operations, `obuf_ext_wr` is high in cycle 10. `obuf_pdu_id`, `obuf_pos` and `obuf_len` then equal the ROM words read in cycles 6, 7 and 8.
- R10: An undefined code runs as a receive but writes neither the output buffer nor the PDU memory. It raises `err` in cycle 11, together with `done`.
- R11: After reset and before any start, all strobes, `done` and `err` are low, and `imem_addr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an instruction (sampled while idle) |
| imem_rd | output | 1 | Instruction fetch strobe |
| imem_addr | output | 8 | Instruction counter |
| imem_data | input | 15 | Fetched instruction word |
| rom_rd | output | 1 | Property ROM read strobe |
| rom_addr | output | 7 | Property ROM word address |
| rom_data | input | 16 | Property ROM word |
| addr_sel | output | 3 | Address multiplexer select |
| addr_ld | output | 5 | Address register load enables |
| pdu_rd | output | 1 | PDU window read strobe |
| pdu_addr | output | 8 | PDU window address |
| pdu_rdata | input | 64 | PDU window read data |
| pdu_wr | output | 1 | PDU window write strobe |
| pdu_wdata | output | 64 | PDU window write data |
| place_props | output | 16 | Latched placement properties word |
| obuf_wr | output | 1 | Output buffer write strobe |
| obuf_data | output | 64 | Window or extracted value |
| obuf_ext_wr | output | 1 | Output buffer write of the long fields |
| obuf_pdu_id | output | 16 | Real PDU id |
| obuf_pos | output | 16 | Real start position |
| obuf_len | output | 16 | Real length |
| done | output | 1 | Instruction complete pulse |
| err | output | 1 | Undefined opcode flag |

## Verification
In cycle 10, the PDU write-back and the output-buffer write fire together for sends. For long operations the long-field buffer write fires in the same cycle. Every opcode is swept over every signal id, so that each combination of the three cycle-10 strobes occurs. The two data outputs are compared against values the bench computes independently from its ROM and PDU models. A start is also held high in the middle of each instruction, which puts an ignored start in the same cycles as the ROM reads; the fetch count and the `done` timing then show that it had no effect.

// File: rtl/sig_seq_pkg.sv
package sig_seq_pkg;
  localparam int OP_W = 3;
  localparam int NPTR = 5;

  localparam logic [OP_W-1:0] OPC_SEND   = 3'd0;
  localparam logic [OP_W-1:0] OPC_RECV   = 3'd1;
  localparam logic [OP_W-1:0] OPC_SEND_L = 3'd2;
  localparam logic [OP_W-1:0] OPC_RECV_L = 3'd3;

  typedef enum logic [2:0] {
    SEL_LO = 3'd0, SEL_HI = 3'd1, SEL_P1 = 3'd2, SEL_P2 = 3'd3, SEL_P3 = 3'd4
  } sel_e;

  // word offset inside a signal's 8-word property record, per pointer
  function automatic logic [2:0] ptr_offset(input int idx);
    return (idx < 2) ? 3'(idx + 2) : 3'(idx + 3);
  endfunction
endpackage

// File: rtl/sig_seq_timer.sv
module sig_seq_timer #(
  parameter int NSTEP = 12,
  localparam int SW = $clog2(NSTEP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic          busy,
  output logic [SW-1:0] step
);
  localparam logic [SW-1:0] LAST = SW'(NSTEP - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      step <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        step <= '0;
      end
    end else if (step == LAST) begin
      busy <= 1'b0;
      step <= '0;
    end else begin
      step <= step + 1'b1;
    end
  end

  a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && step == '0));
  a_r1_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step != LAST) |=> (busy && step == $past(step) + 1'b1));
  a_r1_retire: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && step == LAST) |=> !busy);
  a_r2_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && step != LAST) |=> (busy && step != '0));
endmodule

// File: rtl/sig_seq_addr.sv
module sig_seq_addr
  import sig_seq_pkg::*;
#(
  parameter int ID_W = 4,
  localparam int RA_W = ID_W + 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [ID_W-1:0] sig_id,
  input  logic [NPTR-1:0] ld,
  input  logic            sel_ld,
  input  sel_e            sel_nxt,
  output sel_e            sel,
  output logic [RA_W-1:0] rom_addr
);
  logic [NPTR-1:0][RA_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
      sel <= SEL_LO;
    end else begin
      for (int i = 0; i < NPTR; i++)
        if (ld[i]) ptr[i] <= {sig_id, ptr_offset(i)};
      if (sel_ld) sel <= sel_nxt;
    end
  end

  assign rom_addr = ptr[sel];

  a_r4_single_load: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ld));
  a_r4_load_order: assert property (@(posedge clk) disable iff (!rst_n)
    ld[1] |-> $past(ld[0]));
endmodule

// File: rtl/sig_seq_ctrl.sv
module sig_seq_ctrl
  import sig_seq_pkg::*;
#(
  parameter int ID_W  = 4,
  parameter int VAL_W = 8,
  parameter int PC_W  = 8,
  parameter int RD_W  = 16,
  parameter int PA_W  = 8,
  parameter int WIN_W = 64,
  localparam int IW    = OP_W + ID_W + VAL_W,
  localparam int RA_W  = ID_W + 3,
  localparam int NSTEP = 12,
  localparam int SW    = $clog2(NSTEP)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             imem_rd,
  output logic [PC_W-1:0]  imem_addr,
  input  logic [IW-1:0]    imem_data,
  output logic             rom_rd,
  output logic [RA_W-1:0]  rom_addr,
  input  logic [RD_W-1:0]  rom_data,
  output logic [2:0]       addr_sel,
  output logic [NPTR-1:0]  addr_ld,
  output logic             pdu_rd,
  output logic [PA_W-1:0]  pdu_addr,
  input  logic [WIN_W-1:0] pdu_rdata,
  output logic             pdu_wr,
  output logic [WIN_W-1:0] pdu_wdata,
  output logic [RD_W-1:0]  place_props,
  output logic             obuf_wr,
  output logic [WIN_W-1:0] obuf_data,
  output logic             obuf_ext_wr,
  output logic [RD_W-1:0]  obuf_pdu_id,
  output logic [RD_W-1:0]  obuf_pos,
  output logic [RD_W-1:0]  obuf_len,
  output logic             done,
  output logic             err
);
  // pass-through stand-in for the placement datapath
  function automatic logic [WIN_W-1:0] merge_window(
      input logic [WIN_W-1:0] win, input logic [VAL_W-1:0] val, input logic snd);
    if (snd) return {win[WIN_W-1:VAL_W], val};
    return {{(WIN_W-VAL_W){1'b0}}, win[VAL_W-1:0]};
  endfunction

  logic          busy;
  logic [SW-1:0] step;
  logic [NSTEP-1:0] st;   // one-hot cycle markers

  sig_seq_timer #(.NSTEP(NSTEP)) u_timer (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .step(step));

  for (genvar k = 0; k < NSTEP; k++) begin : g_st
    assign st[k] = busy && (step == SW'(k));
  end

  logic [IW-1:0]    ir_q;
  logic [PC_W-1:0]  pc_q;
  logic [OP_W-1:0]  op;
  logic [ID_W-1:0]  id;
  logic [VAL_W-1:0] val;
  logic op_long, op_send, op_ok;

  assign op      = ir_q[IW-1 -: OP_W];
  assign id      = ir_q[VAL_W +: ID_W];
  assign val     = ir_q[VAL_W-1:0];
  assign op_long = (op == OPC_SEND_L) || (op == OPC_RECV_L);
  assign op_send = (op == OPC_SEND) || (op == OPC_SEND_L);
  assign op_ok   = op_long || op_send || (op == OPC_RECV);

  // address registers and select steering
  logic sel_ld;
  sel_e sel_nxt, sel;

  assign addr_ld = {st[5] & op_long, st[4] & op_long, st[3] & op_long, st[2], st[1]};
  assign sel_ld  = st[3] | st[4] | (op_long & (st[5] | st[6] | st[7]));

  always_comb begin
    sel_nxt = SEL_LO;
    if (st[4]) sel_nxt = SEL_HI;
    if (st[5]) sel_nxt = SEL_P1;
    if (st[6]) sel_nxt = SEL_P2;
    if (st[7]) sel_nxt = SEL_P3;
  end

  sig_seq_addr #(.ID_W(ID_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .sig_id(id), .ld(addr_ld),
    .sel_ld(sel_ld), .sel_nxt(sel_nxt), .sel(sel), .rom_addr(rom_addr));

  assign addr_sel = sel;
  assign rom_rd   = st[4] | st[5] | (op_long & (st[6] | st[7] | st[8]));

  // data registers
  logic [PA_W-1:0]  win_q;
  logic [WIN_W-1:0] orig_q, shad_q, fin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_q <= '0; pc_q <= '0; win_q <= '0; place_props <= '0;
      orig_q <= '0; shad_q <= '0; fin_q <= '0;
      obuf_pdu_id <= '0; obuf_pos <= '0; obuf_len <= '0;
    end else begin
      if (st[0]) begin
        ir_q <= imem_data;
        pc_q <= pc_q + 1'b1;
      end
      if (st[4]) win_q <= rom_data[PA_W-1:0];
      if (st[5]) place_props <= rom_data;
      if (st[6]) orig_q <= pdu_rdata;
      if (st[6] && op_long) obuf_pdu_id <= rom_data;
      if (st[7] && op_long) obuf_pos <= rom_data;
      if (st[8] && op_long) obuf_len <= rom_data;
      if (st[7]) shad_q <= orig_q;
      if (st[8]) shad_q <= merge_window(shad_q, val, op_send);
      if (st[9]) fin_q <= shad_q;
    end
  end

  assign imem_rd     = st[0];
  assign imem_addr   = pc_q;
  assign pdu_rd      = st[6];
  assign pdu_addr    = win_q;
  assign pdu_wr      = st[10] & op_send;
  assign pdu_wdata   = fin_q;
  assign obuf_wr     = st[10] & op_ok;
  assign obuf_data   = fin_q;
  assign obuf_ext_wr = st[10] & op_long;
  assign done        = st[11];
  assign err         = st[11] & ~op_ok;

  a_r1_done_after_fetch: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(imem_rd, 11));
  a_r5_low_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd && addr_sel == 3'd0) |-> (rom_addr == {id, 3'd2}));
  a_r5_high_word: assert property (@(posedge clk) disable iff (!rst_n)
    (rom_rd && addr_sel == 3'd1) |-> (rom_addr == {id, 3'd3}));
  a_r6_pdu_after_rom: assert property (@(posedge clk) disable iff (!rst_n)
    pdu_rd |-> ($past(rom_rd) && $past(rom_rd, 2)));
  a_r7_writeback_addr: assert property (@(posedge clk) disable iff (!rst_n)
    pdu_wr |-> ($past(pdu_rd, 4) && pdu_addr == $past(pdu_addr, 4)));
  a_r9_ext_reads: assert property (@(posedge clk) disable iff (!rst_n)
    obuf_ext_wr |-> ($past(rom_rd, 2) && $past(rom_rd, 3) && $past(rom_rd, 4)));
  a_r10_bad_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (done && !$past(obuf_wr) && !$past(pdu_wr)));
endmodule

// File: tb/sig_seq_ctrl_tb.sv
module sig_seq_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic        imem_rd, rom_rd, pdu_rd, pdu_wr, obuf_wr, obuf_ext_wr, done, err;
  logic [7:0]  imem_addr, pdu_addr;
  logic [14:0] imem_data;
  logic [6:0]  rom_addr;
  logic [15:0] rom_data, place_props, obuf_pdu_id, obuf_pos, obuf_len;
  logic [2:0]  addr_sel;
  logic [4:0]  addr_ld;
  logic [63:0] pdu_rdata, pdu_wdata, obuf_data;

  logic [14:0] imem [256];

  function automatic logic [15:0] rom_word(input logic [6:0] a);
    return (16'(a) * 16'd41) ^ 16'h5A3C;
  endfunction
  function automatic logic [63:0] pdu_word(input logic [7:0] a);
    return {8{a}} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  assign imem_data = imem[imem_addr];
  assign rom_data  = rom_word(rom_addr);
  assign pdu_rdata = pdu_word(pdu_addr);

  sig_seq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .imem_rd(imem_rd), .imem_addr(imem_addr), .imem_data(imem_data),
    .rom_rd(rom_rd), .rom_addr(rom_addr), .rom_data(rom_data),
    .addr_sel(addr_sel), .addr_ld(addr_ld),
    .pdu_rd(pdu_rd), .pdu_addr(pdu_addr), .pdu_rdata(pdu_rdata),
    .pdu_wr(pdu_wr), .pdu_wdata(pdu_wdata), .place_props(place_props),
    .obuf_wr(obuf_wr), .obuf_data(obuf_data), .obuf_ext_wr(obuf_ext_wr),
    .obuf_pdu_id(obuf_pdu_id), .obuf_pos(obuf_pos), .obuf_len(obuf_len),
    .done(done), .err(err));

  int vectors = 0;
  int fails = 0;
  logic [7:0] pc_exp = 8'd0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic run_instr(input logic [2:0] op, input logic [3:0] id, input logic [7:0] val);
    logic lng, snd, ok;
    logic [6:0] base;
    logic [63:0] win, fin;
    lng  = (op == 3'd2) || (op == 3'd3);
    snd  = (op == 3'd0) || (op == 3'd2);
    ok   = (op <= 3'd3);
    base = {id, 3'b000};
    win  = pdu_word(rom_word(base + 7'd2)[7:0]);
    fin  = snd ? {win[63:8], val} : {56'd0, win[7:0]};
    imem[pc_exp] = {op, id, val};
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int c = 0; c < 12; c++) begin
      logic [4:0] ld_e;
      logic rd_e;
      if (c > 0) @(negedge clk);
      if (c == 4) start = 1'b1;          // R2: start during a busy instruction
      if (c == 7) start = 1'b0;
      chk("R1 fetch strobe", 64'(imem_rd), 64'(c == 0));
      if (c == 0) chk("R1 fetch address", 64'(imem_addr), 64'(pc_exp));
      ld_e = 5'd0;
      if (c == 1) ld_e = 5'b00001;
      if (c == 2) ld_e = 5'b00010;
      if (lng && c >= 3 && c <= 5) ld_e = 5'(1 << (c - 1));
      chk("R4 load enables", 64'(addr_ld), 64'(ld_e));
      rd_e = (c == 4) || (c == 5) || (lng && c >= 6 && c <= 8);
      chk("R5 rom read strobe", 64'(rom_rd), 64'(rd_e));
      if (rd_e) begin
        logic [2:0] off;
        off = (c == 4) ? 3'd2 : (c == 5) ? 3'd3 : 3'(c - 1);
        chk("R5 rom address", 64'(rom_addr), 64'(base + 7'(off)));
        chk("R5 mux select", 64'(addr_sel), 64'(c - 4));
      end
      chk("R6 pdu read strobe", 64'(pdu_rd), 64'(c == 6));
      if (c == 6) chk("R6 pdu address", 64'(pdu_addr), 64'(rom_word(base + 7'd2)[7:0]));
      if (c == 10) chk("R6 placement word", 64'(place_props), 64'(rom_word(base + 7'd3)));
      chk("R7 pdu write strobe", 64'(pdu_wr), 64'(c == 10 && snd));
      if (c == 10 && snd) begin
        chk("R7 pdu write data", pdu_wdata, fin);
        chk("R7 pdu write address", 64'(pdu_addr), 64'(rom_word(base + 7'd2)[7:0]));
      end
      chk(ok ? "R8 obuf strobe" : "R10 obuf suppressed", 64'(obuf_wr), 64'(c == 10 && ok));
      if (c == 10 && ok) chk("R8 obuf data", obuf_data, fin);
      chk("R9 ext strobe", 64'(obuf_ext_wr), 64'(c == 10 && lng));
      if (c == 10 && lng) begin
        chk("R9 real pdu id", 64'(obuf_pdu_id), 64'(rom_word(base + 7'd5)));
        chk("R9 real position", 64'(obuf_pos), 64'(rom_word(base + 7'd6)));
        chk("R9 real length", 64'(obuf_len), 64'(rom_word(base + 7'd7)));
      end
      chk("R1 done pulse", 64'(done), 64'(c == 11));
      chk("R10 error flag", 64'(err), 64'(c == 11 && !ok));
    end
    @(negedge clk);
    chk("R2 no refetch after done", 64'(imem_rd), 64'd0);
    chk("R1 idle after done", 64'(done), 64'd0);
    pc_exp = pc_exp + 8'd1;
  endtask

  initial begin
    for (int i = 0; i < 256; i++) imem[i] = '0;
    repeat (3) @(negedge clk);
    chk("R11 reset fetch", 64'(imem_rd), 64'd0);
    chk("R11 reset rom", 64'(rom_rd), 64'd0);
    chk("R11 reset pdu", 64'({pdu_rd, pdu_wr}), 64'd0);
    chk("R11 reset obuf", 64'({obuf_wr, obuf_ext_wr}), 64'd0);
    chk("R11 reset done err", 64'({done, err}), 64'd0);
    chk("R11 reset counter", 64'(imem_addr), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 idle without start", 64'(imem_rd), 64'd0);
    for (int op = 0; op < 8; op++)       // R3: every code over every id
      for (int id = 0; id < 16; id++)
        run_instr(3'(op), 4'(id), 8'(id * 29 + op * 7 + 3));
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    vectors++;
    fails++;
    $display("FAIL R1 watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule